// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block decides, every cycle, whether a hart has to take an interrupt and which one. It takes the pending vector, the enable vector, the delegation mask, the current privilege level and the two global interrupt-enable bits (machine and supervisor). It returns a take flag and a cause index.

Candidates are the bits that are both pending and enabled. Each candidate then passes through one of two gates. A candidate whose delegation bit is 0 goes through the machine gate. A candidate whose delegation bit is 1 goes through the supervisor gate. Each gate opens or closes from the privilege level and the matching global enable. Among the survivors the lowest index wins.

The selection logic is combinational. A parameter picks whether the result leaves through an output register (the default, one cycle of latency) or leaves directly. The privilege decode is written as a case over a named privilege enumeration: user, supervisor, reserved and machine. Each value maps to a fixed pair of gate conditions. There is no sequential state besides the optional output register.

Top module: `irq_pend_select`

## Requirements
- R1: An interrupt is a candidate only when both its pending bit and its enable bit are 1. With no candidate bit set, `take_o` is 0.
- R2: Non-delegated candidates (delegation bit 0) are kept when privilege is below machine. At machine privilege (code 3) they are kept only when `mach_gie_i` is 1.
- R3: Delegated candidates (delegation bit 1) are kept when privilege is user (code 0). At supervisor privilege (code 1) they are kept only when `sup_gie_i` is 1. At machine privilege they are always dropped.
- R4: The delegation bit of each candidate alone decides which of the two gates applies to it. A dropped delegated bit does not block a kept non-delegated bit, and the reverse also holds.
- R5: When several candidates survive, `cause_o` is the index of the least significant surviving bit.
- R6: When no candidate survives, `take_o` is 0 and `cause_o` is 0.
- R7: With `REG_OUT`=1, the outputs show the decision for the inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are 0.
- R8: Privilege code 2 (reserved) counts as below machine and not below supervisor. Non-delegated candidates are kept and delegated ones are dropped.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 32 | Pending interrupt vector |
| en_i | input | 32 | Interrupt enable vector |
| deleg_i | input | 32 | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mach_gie_i | input | 1 | Global machine interrupt enable |
| sup_gie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| cause_o | output | 5 | Index of the chosen interrupt, 0 when `take_o` is 0 |

## Verification
Several properties are checked on every cycle against inputs the checker re-times itself:
- the cause index is 0 whenever nothing is taken;
- a taken index is always a pending and enabled bit;
- nothing is taken at machine level with the machine enable clear;
- a taken delegated index implies an open supervisor gate;
- user level always takes something when a candidate exists.

The least-significant-bit choice among several survivors, the independence of the two gates, the reserved privilege code and the one-cycle latency are shown by the bench's directed and random scenarios. These compare every result with a reference function.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Privilege encoding used by the selector.
    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUPV = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MACH = 2'd3
    } priv_e;

    // The two level gates derived from privilege and global enables.
    typedef struct packed {
        logic mach_open;
        logic sup_open;
    } gate_t;

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_sel_pkg::*;
#(
    parameter int VEC_W = 32
) (
    input  logic [VEC_W-1:0] pend_i,
    input  logic [VEC_W-1:0] en_i,
    input  logic [VEC_W-1:0] deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mach_gie_i,
    input  logic             sup_gie_i,
    output logic [VEC_W-1:0] live_o
);

    priv_e             priv;
    gate_t             gate;
    logic [VEC_W-1:0]  cand;

    assign priv = priv_e'(priv_i);
    assign cand = pend_i & en_i;

    // Privilege decode: each level maps to a fixed pair of gate conditions.
    always_comb begin
        gate = '0;
        unique case (priv)
            PRIV_USER: begin
                gate.mach_open = 1'b1;
                gate.sup_open  = 1'b1;
            end
            PRIV_SUPV: begin
                gate.mach_open = 1'b1;
                gate.sup_open  = sup_gie_i;
            end
            PRIV_RSVD: begin
                gate.mach_open = 1'b1;
                gate.sup_open  = 1'b0;
            end
            PRIV_MACH: begin
                gate.mach_open = mach_gie_i;
                gate.sup_open  = 1'b0;
            end
            default: gate = '0;
        endcase
    end

    // Split by delegation: each bit passes through its own gate.
    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        assign live_o[b] = cand[b] & (deleg_i[b] ? gate.sup_open : gate.mach_open);
    end

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int VEC_W = 32,
    localparam int IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] live_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = VEC_W - 1; i >= 0; i--) begin
            if (live_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |live_i;

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
    parameter int IDX_W   = 5,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             take_o,
    output logic [IDX_W-1:0] cause_o
);

    logic [IDX_W-1:0] idx_gated;

    // Force the index to 0 whenever nothing is taken.
    assign idx_gated = any_i ? idx_i : '0;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                take_o  <= 1'b0;
                cause_o <= '0;
            end else begin
                take_o  <= any_i;
                cause_o <= idx_gated;
            end
        end
    end else begin : g_comb
        assign take_o  = any_i;
        assign cause_o = idx_gated;
    end

endmodule

// File: rtl/irq_pend_select.sv
module irq_pend_select #(
    parameter int VEC_W   = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int IDX_W  = $clog2(VEC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] pend_i,
    input  logic [VEC_W-1:0] en_i,
    input  logic [VEC_W-1:0] deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             mach_gie_i,
    input  logic             sup_gie_i,
    output logic             take_o,
    output logic [IDX_W-1:0] cause_o
);

    logic [VEC_W-1:0] live;
    logic             any;
    logic [IDX_W-1:0] idx;

    irq_gate #(.VEC_W(VEC_W)) u_gate (
        .pend_i     (pend_i),
        .en_i       (en_i),
        .deleg_i    (deleg_i),
        .priv_i     (priv_i),
        .mach_gie_i (mach_gie_i),
        .sup_gie_i  (sup_gie_i),
        .live_o     (live)
    );

    irq_lsb_pick #(.VEC_W(VEC_W)) u_pick (
        .live_i (live),
        .any_o  (any),
        .idx_o  (idx)
    );

    irq_out_stage #(.IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_i   (any),
        .idx_i   (idx),
        .take_o  (take_o),
        .cause_o (cause_o)
    );

endmodule

// File: rtl/irq_pend_select_chk.sv
module irq_pend_select_chk #(
    parameter int VEC_W   = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int IDX_W  = $clog2(VEC_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] pend_i,
    input logic [VEC_W-1:0] en_i,
    input logic [VEC_W-1:0] deleg_i,
    input logic [1:0]       priv_i,
    input logic             mach_gie_i,
    input logic             sup_gie_i,
    input logic             take_o,
    input logic [IDX_W-1:0] cause_o
);

    // Inputs re-timed to line up with the outputs they produced.
    logic [VEC_W-1:0] c_pend, c_en, c_deleg;
    logic [1:0]       c_priv;
    logic             c_mgie, c_sgie;

    if (REG_OUT) begin : g_align
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c_pend <= '0; c_en <= '0; c_deleg <= '0;
                c_priv <= '0; c_mgie <= 1'b0; c_sgie <= 1'b0;
            end else begin
                c_pend <= pend_i; c_en <= en_i; c_deleg <= deleg_i;
                c_priv <= priv_i; c_mgie <= mach_gie_i; c_sgie <= sup_gie_i;
            end
        end
    end else begin : g_direct
        assign c_pend = pend_i;  assign c_en = en_i;  assign c_deleg = deleg_i;
        assign c_priv = priv_i;  assign c_mgie = mach_gie_i; assign c_sgie = sup_gie_i;
    end

    AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> cause_o == '0); // R6
    AST_PICK_IS_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (c_pend[cause_o] && c_en[cause_o])); // R1
    AST_NO_CAND_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_pend & c_en) == '0 |-> !take_o); // R1
    AST_MACH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (c_priv == 2'd3 && !c_mgie) |-> !take_o); // R2
    AST_DELEG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && c_deleg[cause_o]) |-> (c_priv == 2'd0 || (c_priv == 2'd1 && c_sgie))); // R3
    AST_USER_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (c_priv == 2'd0 && (c_pend & c_en) != '0) |-> take_o); // R4

endmodule

bind irq_pend_select irq_pend_select_chk #(.VEC_W(VEC_W), .REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_i     (pend_i),
    .en_i       (en_i),
    .deleg_i    (deleg_i),
    .priv_i     (priv_i),
    .mach_gie_i (mach_gie_i),
    .sup_gie_i  (sup_gie_i),
    .take_o     (take_o),
    .cause_o    (cause_o)
);

// File: tb/irq_pend_select_test.sv
`timescale 1ns/1ps
module irq_pend_select_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pend = '0, en = '0, deleg = '0;
    logic [1:0]  priv = '0;
    logic        mgie = 1'b0, sgie = 1'b0;
    logic        take;
    logic [4:0]  cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_pend_select uut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .priv_i(priv), .mach_gie_i(mgie), .sup_gie_i(sgie),
        .take_o(take), .cause_o(cause)
    );

    // Reference model, written from the requirements.
    function automatic logic [31:0] ref_live(input logic [31:0] p, e, d,
                                             input logic [1:0] pr, input logic mg, sg);
        logic m_ok, s_ok;
        m_ok = (pr < 2'd3) || (pr == 2'd3 && mg);
        s_ok = (pr < 2'd1) || (pr == 2'd1 && sg);
        return (p & e & ~d & {32{m_ok}}) | (p & e & d & {32{s_ok}});
    endfunction

    function automatic logic [4:0] ref_idx(input logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] p, e, d, input logic [1:0] pr,
                         input logic mg, sg, input string tag);
        logic [31:0] lv;
        @(negedge clk);
        pend = p; en = e; deleg = d; priv = pr; mgie = mg; sgie = sg;
        lv = ref_live(p, e, d, pr, mg, sg);
        @(posedge clk);
        @(negedge clk);
        check({tag, " take"}, 32'(take), 32'(lv != '0));
        check({tag, " cause"}, 32'(cause), 32'(ref_idx(lv)));
    endtask

    initial begin
        void'($urandom(32'h1dc0_5eed));
        // R7: reset clears outputs even with live inputs
        pend = 32'hFFFF_FFFF; en = 32'hFFFF_FFFF; priv = 2'd0;
        repeat (3) @(negedge clk);
        check("R7 reset take", 32'(take), 32'd0);
        check("R7 reset cause", 32'(cause), 32'd0);
        rst_n = 1'b1;

        apply(32'h0000_0010, 32'h0000_0000, 32'h0, 2'd0, 1'b1, 1'b1, "R1 pending not enabled");
        apply(32'h0000_0100, 32'h0000_0100, 32'h0, 2'd3, 1'b0, 1'b1, "R2 machine gie clear");
        apply(32'h0000_0100, 32'h0000_0100, 32'h0, 2'd3, 1'b1, 1'b0, "R2 machine gie set");
        apply(32'h0000_0100, 32'h0000_0100, 32'h0, 2'd1, 1'b0, 1'b0, "R2 below machine");
        apply(32'h0000_0020, 32'h0000_0020, 32'h20, 2'd1, 1'b1, 1'b0, "R3 supv gie clear");
        apply(32'h0000_0020, 32'h0000_0020, 32'h20, 2'd1, 1'b0, 1'b1, "R3 supv gie set");
        apply(32'h0000_0020, 32'h0000_0020, 32'h20, 2'd3, 1'b1, 1'b1, "R3 machine drops delegated");
        apply(32'h0000_0202, 32'hFFFF_FFFF, 32'h2, 2'd1, 1'b1, 1'b0, "R4 delegated dropped undelegated kept");
        apply(32'h0000_0202, 32'hFFFF_FFFF, 32'h200, 2'd3, 1'b0, 1'b1, "R4 undelegated dropped");
        apply(32'h8000_0080, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b0, 1'b0, "R5 lowest wins");
        apply(32'h8000_0000, 32'h8000_0000, 32'h0, 2'd0, 1'b0, 1'b0, "R5 top bit");
        apply(32'h0, 32'hFFFF_FFFF, 32'h0, 2'd0, 1'b1, 1'b1, "R6 none pending");
        apply(32'h0000_0401, 32'hFFFF_FFFF, 32'h1, 2'd2, 1'b0, 1'b1, "R8 reserved level");
        apply(32'h0000_0001, 32'hFFFF_FFFF, 32'h1, 2'd2, 1'b1, 1'b1, "R8 reserved drops delegated");

        // R7: new inputs are not visible before the next rising edge
        @(negedge clk);
        pend = 32'h4; en = 32'h4; deleg = 32'h0; priv = 2'd0;
        #1 check("R7 latency hold take", 32'(take), 32'd0);
        @(posedge clk); @(negedge clk);
        check("R7 latency update cause", 32'(cause), 32'd2);

        // Random sweep across every privilege code (R2 R3 R4 R5)
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] p, e, d;
            p = $urandom() & $urandom();
            if (k % 3 == 0) p = p & ($urandom() << ($urandom() % 24));
            e = $urandom() | $urandom();
            d = $urandom();
            apply(p, e, d, 2'(k % 4), 1'($urandom()), 1'($urandom()), "R5 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule